// File: doc/BRIEF.md
# Speed Reference Divider with Phase Comparator and Lock Judge

This block produces the speed reference for a spindle-motor control loop and compares it with the motor's tachometer feedback. A fast base clock is divided by one of three ratios to give a square-wave reference. That reference is normally routed back in through a separate reference input, so an external divider can be placed in the loop if needed. The falling edges of the reference input are compared with the valid edges of the feedback pulse train in a two-flip-flop phase-frequency detector. Its up and down pump pulses are as wide as the phase error, in base-clock cycles. An enable output goes high only while a pump pulse is active, so an off-chip charge pump can release its node to high impedance the rest of the time.

Feedback qualification has two settings. In single-edge mode only falling feedback edges are valid. In dual-edge mode both edges are valid, so for a given reference frequency the motor runs at half the tachometer rate. The lock judge looks only at the width of each finished comparison, never at speed. It declares lock after a run of narrow comparisons and drops lock at the first wide one. Lock is reported in both true and inverted form.

All pins are plain level signals sampled on the rising clock edge. The block carries no data stream, so it has no handshake and no back-pressure.

Top module: `spd_ref_phase_ctl`

## Requirements
- R1: `ratio_sel` picks the reference ratio. 2'b00 gives PRE_DIV*DIV_LOW (3072 by default), 2'b01 gives PRE_DIV*DIV_MID (1024), and 2'b10 or 2'b11 gives PRE_DIV*DIV_HIGH (4096, also the open-pin setting). `ref_out` is high for the first half of each period and low for the second half.
- R2: A new `ratio_sel` value is adopted only in the first cycle of a reference period. The period in progress finishes at its old length with both half-phases intact, and the next period uses the new ratio.
- R3: With `dual_edge` = 0, only falling edges of `fb_in` are valid. A rising edge of `fb_in` leaves `pump_dn` low.
- R4: With `dual_edge` = 1, rising and falling edges of `fb_in` are both valid. Either edge sets `pump_dn` when no comparison is pending.
- R5: Only falling edges of `ref_in` take part in the comparison. A rising edge of `ref_in` leaves `pump_up` low.
- R6: A pin change seen at rising edge k raises the pump output after edge k+1. If the reference edge leads by d cycles, `pump_up` is high for exactly d cycles and `pump_dn` stays low. If the feedback edge leads, `pump_dn` behaves the same way. If the two edges arrive in the same cycle, neither pump pulses.
- R7: `pump_en` is high exactly when `pump_up` or `pump_dn` is high, and low otherwise.
- R8: `lock` rises after LOCK_CMP consecutive finished comparisons (8 by default), each with a pulse width below `lock_win` cycles. A zero-width (coincident) comparison counts as narrow. With `lock_win` = 0, lock never asserts.
- R9: A finished comparison whose width is `lock_win` or more clears `lock` at the next edge. A width of `lock_win`-1 keeps it.
- R10: `lock_n` is always the inverse of `lock`.
- R11: While `rst_n` is low: both pumps and `pump_en` are low, `lock` is low, `lock_n` is high and `ref_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_sel | input | 2 | Reference ratio select (00 low, 01 middle, 1x high/open) |
| ref_out | output | 1 | Divided reference square wave |
| ref_in | input | 1 | Reference taken into the comparator (normally tied to ref_out) |
| fb_in | input | 1 | Tachometer comparator output |
| dual_edge | input | 1 | 1: both feedback edges valid; 0: falling edges only |
| lock_win | input | WIN_W | Lock window in cycles |
| pump_up | output | 1 | Speed-up pulse |
| pump_dn | output | 1 | Slow-down pulse |
| pump_en | output | 1 | High while the charge pump is driven; low means high impedance |
| lock | output | 1 | Phase lock flag |
| lock_n | output | 1 | Inverted phase lock flag |

## Verification
A reference fall and a feedback edge can be qualified in the same cycle. The detector must then neither pulse nor leave a pending state, while the lock judge still counts a finished zero-width comparison. The bench provokes this by dropping both inputs on the same falling clock edge. It checks that the pump-pulse totals stay at zero, and that this coincident comparison, placed eighth in a run of narrow ones, is the one that raises lock. The other collision is a ratio change made mid-period; it is judged by measuring the period in progress and the period after it.

// File: rtl/spdref_pkg.sv
package spdref_pkg;

  typedef logic [1:0] rsel_t;

  typedef enum logic [1:0] {
    STG_LOW  = 2'd0,
    STG_MID  = 2'd1,
    STG_HIGH = 2'd2
  } stage_e;

  // Select code to second-stage ratio; both 1x codes mean high/open
  function automatic stage_e decode_sel(input rsel_t s);
    case (s)
      2'b00:   decode_sel = STG_LOW;
      2'b01:   decode_sel = STG_MID;
      default: decode_sel = STG_HIGH;
    endcase
  endfunction

endpackage

// File: rtl/ref_divider.sv
module ref_divider
  import spdref_pkg::*;
#(
  parameter int PRE_DIV  = 8,
  parameter int DIV_LOW  = 384,
  parameter int DIV_MID  = 128,
  parameter int DIV_HIGH = 512
) (
  input  logic  clk,
  input  logic  rst_n,
  input  rsel_t ratio_sel,
  output logic  ref_out
);

  localparam int DIV_MAX = (DIV_HIGH > DIV_LOW) ?
                           ((DIV_HIGH > DIV_MID) ? DIV_HIGH : DIV_MID) :
                           ((DIV_LOW > DIV_MID) ? DIV_LOW : DIV_MID);
  localparam int PC_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int SC_W = $clog2(DIV_MAX);

  stage_e          cur_q;
  logic [PC_W-1:0] pc_q;
  logic [SC_W-1:0] sc_q;
  logic [SC_W-1:0] last_sc;
  logic [SC_W-1:0] half_sc;
  logic            pre_tick;
  logic            wrap;
  logic            at_start;

  always_comb begin
    case (cur_q)
      STG_LOW: begin
        last_sc = SC_W'(DIV_LOW - 1);
        half_sc = SC_W'(DIV_LOW / 2);
      end
      STG_MID: begin
        last_sc = SC_W'(DIV_MID - 1);
        half_sc = SC_W'(DIV_MID / 2);
      end
      default: begin
        last_sc = SC_W'(DIV_HIGH - 1);
        half_sc = SC_W'(DIV_HIGH / 2);
      end
    endcase
  end

  assign pre_tick = (pc_q == PC_W'(PRE_DIV - 1));
  assign wrap     = pre_tick && (sc_q == last_sc);
  assign at_start = (pc_q == '0) && (sc_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sc_q  <= '0;
      cur_q <= STG_HIGH;
    end else begin
      pc_q <= pre_tick ? '0 : pc_q + 1'b1;
      if (pre_tick) sc_q <= wrap ? '0 : sc_q + 1'b1;
      // New ratio taken only in the first cycle of a period: no runt phase
      if (at_start) cur_q <= decode_sel(ratio_sel);
    end
  end

  assign ref_out = (sc_q < half_sc);

  // R1: a reference period begins only where the chain wraps
  assert_rise_at_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_out) |-> $past(wrap));

  // R2: the active ratio changes only in the first cycle of a period
  assert_ratio_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_q) |-> $past(at_start));

endmodule

// File: rtl/edge_qual.sv
module edge_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  input  logic both_en,
  output logic ev
);

  logic s1_q;
  logic s2_q;

  // Idle level is high so that release from reset gives no false edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= sig;
      s2_q <= s1_q;
    end
  end

  assign ev = (s2_q && !s1_q) || (both_en && !s2_q && s1_q);

endmodule

// File: rtl/phase_freq_det.sv
module phase_freq_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ev,
  input  logic fb_ev,
  output logic up,
  output logic dn,
  output logic done
);

  logic up_q;
  logic dn_q;
  logic nxt_up;
  logic nxt_dn;

  assign nxt_up = up_q || ref_ev;
  assign nxt_dn = dn_q || fb_ev;
  assign done   = nxt_up && nxt_dn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= done ? 1'b0 : nxt_up;
      dn_q <= done ? 1'b0 : nxt_dn;
    end
  end

  assign up = up_q;
  assign dn = dn_q;

  // R6: an up pulse starts only after a qualified reference edge
  assert_up_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_q) |-> $past(ref_ev));

  // R6: a down pulse starts only after a qualified feedback edge
  assert_dn_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_q) |-> $past(fb_ev));

endmodule

// File: rtl/lock_judge.sv
module lock_judge #(
  parameter int ERR_W    = 16,
  parameter int WIN_W    = 12,
  parameter int LOCK_CMP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             active,
  input  logic [WIN_W-1:0] win,
  output logic             lock
);

  localparam int LC_W = $clog2(LOCK_CMP + 1);

  logic [ERR_W-1:0] err_q;
  logic [LC_W-1:0]  run_q;
  logic             lock_q;
  logic [ERR_W:0]   width;
  logic [ERR_W:0]   win_x;
  logic             good;

  // Width of the finishing comparison includes its last active cycle
  assign width = {1'b0, err_q} + (ERR_W+1)'(active);
  assign win_x = (ERR_W+1)'(win);
  assign good  = (width < win_x);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= '0;
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (done) begin
      err_q <= '0;
      if (good) begin
        if (run_q != LC_W'(LOCK_CMP)) run_q <= run_q + 1'b1;
        if (run_q >= LC_W'(LOCK_CMP - 1)) lock_q <= 1'b1;
      end else begin
        run_q  <= '0;
        lock_q <= 1'b0;
      end
    end else if (active && (err_q != '1)) begin
      err_q <= err_q + 1'b1;
    end
  end

  assign lock = lock_q;

  // R8: lock rises only on a finished narrow comparison
  assert_lock_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(done && good));

  // R9: lock falls only on a finished wide comparison
  assert_lock_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(done && !good));

endmodule

// File: rtl/spd_ref_phase_ctl.sv
module spd_ref_phase_ctl
  import spdref_pkg::*;
#(
  parameter int PRE_DIV  = 8,
  parameter int DIV_LOW  = 384,
  parameter int DIV_MID  = 128,
  parameter int DIV_HIGH = 512,
  parameter int ERR_W    = 16,
  parameter int WIN_W    = 12,
  parameter int LOCK_CMP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ratio_sel,
  output logic             ref_out,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic             dual_edge,
  input  logic [WIN_W-1:0] lock_win,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             pump_en,
  output logic             lock,
  output logic             lock_n
);

  localparam int N_CH = 2;  // channel 0: reference, channel 1: feedback

  logic [N_CH-1:0] raw_in;
  logic [N_CH-1:0] both_en;
  logic [N_CH-1:0] edge_ev;
  logic            cmp_done;
  logic            up_w;
  logic            dn_w;

  ref_divider #(
    .PRE_DIV (PRE_DIV),
    .DIV_LOW (DIV_LOW),
    .DIV_MID (DIV_MID),
    .DIV_HIGH(DIV_HIGH)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .ratio_sel(ratio_sel),
    .ref_out  (ref_out)
  );

  assign raw_in  = {fb_in, ref_in};
  assign both_en = {dual_edge, 1'b0};

  for (genvar i = 0; i < N_CH; i++) begin : g_edge
    edge_qual u_q (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig    (raw_in[i]),
      .both_en(both_en[i]),
      .ev     (edge_ev[i])
    );
  end

  phase_freq_det u_pfd (
    .clk   (clk),
    .rst_n (rst_n),
    .ref_ev(edge_ev[0]),
    .fb_ev (edge_ev[1]),
    .up    (up_w),
    .dn    (dn_w),
    .done  (cmp_done)
  );

  lock_judge #(
    .ERR_W   (ERR_W),
    .WIN_W   (WIN_W),
    .LOCK_CMP(LOCK_CMP)
  ) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (cmp_done),
    .active(up_w || dn_w),
    .win   (lock_win),
    .lock  (lock)
  );

  assign pump_up = up_w;
  assign pump_dn = dn_w;
  assign pump_en = up_w || dn_w;
  assign lock_n  = !lock;

endmodule

// File: tb/spd_ref_phase_ctl_test.sv
module spd_ref_phase_ctl_test;

  localparam int PRE = 2;
  localparam int NLO = 48;
  localparam int NMD = 16;
  localparam int NHI = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ratio_sel = 2'b01;
  logic        ref_in = 1'b1;
  logic        fb_in = 1'b1;
  logic        dual_edge = 1'b0;
  logic [11:0] lock_win = 12'd0;
  logic        ref_out, pump_up, pump_dn, pump_en, lock, lock_n;

  int checks = 0;
  int failures = 0;
  int cyc = 0, up_tot = 0, dn_tot = 0, en_bad = 0, lockn_bad = 0;
  int last_rise = 0, last_per = 0, last_high = 0, rise_cnt = 0;
  logic ref_prev = 1'b0;
  logic done_flag = 1'b0;

  // {fb_leads, gap, expected up width, expected dn width}
  localparam logic [24:0] VECS [0:5] = '{
    {1'b0, 8'd3, 8'd3, 8'd0},
    {1'b1, 8'd3, 8'd0, 8'd3},
    {1'b0, 8'd0, 8'd0, 8'd0},
    {1'b0, 8'd1, 8'd1, 8'd0},
    {1'b1, 8'd7, 8'd0, 8'd7},
    {1'b0, 8'd12, 8'd12, 8'd0}
  };

  spd_ref_phase_ctl #(
    .PRE_DIV(PRE), .DIV_LOW(NLO), .DIV_MID(NMD), .DIV_HIGH(NHI),
    .ERR_W(16), .WIN_W(12), .LOCK_CMP(8)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .ref_out(ref_out),
    .ref_in(ref_in), .fb_in(fb_in), .dual_edge(dual_edge), .lock_win(lock_win),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_en(pump_en),
    .lock(lock), .lock_n(lock_n)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (pump_up) up_tot = up_tot + 1;
    if (pump_dn) dn_tot = dn_tot + 1;
    if (pump_en != (pump_up || pump_dn)) en_bad = en_bad + 1;
    if (lock_n == lock) lockn_bad = lockn_bad + 1;
    if (ref_out && !ref_prev) begin
      last_per = cyc - last_rise;
      last_rise = cyc;
      rise_cnt = rise_cnt + 1;
    end
    if (!ref_out && ref_prev) last_high = cyc - last_rise;
    ref_prev = ref_out;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise();
    int r;
    r = rise_cnt;
    while (rise_cnt == r) @(negedge clk);
  endtask

  // One comparison: leading input falls, the other falls gap cycles later
  task automatic compare(input logic fb_lead, input int gap);
    @(negedge clk);
    if (gap == 0) begin
      ref_in = 1'b0; fb_in = 1'b0;
    end else if (!fb_lead) begin
      ref_in = 1'b0;
      repeat (gap) @(negedge clk);
      fb_in = 1'b0;
    end else begin
      fb_in = 1'b0;
      repeat (gap) @(negedge clk);
      ref_in = 1'b0;
    end
    repeat (4) @(negedge clk);
    ref_in = 1'b1; fb_in = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int u0, d0;
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 pump_up", pump_up, 0);
    chk("R11 pump_dn", pump_dn, 0);
    chk("R11 pump_en", pump_en, 0);
    chk("R11 lock", lock, 0);
    chk("R11 lock_n", lock_n, 1);
    chk("R11 ref_out", ref_out, 1);
    rst_n = 1'b1;

    // R1: middle ratio
    wait_rise(); wait_rise(); wait_rise();
    chk("R1 mid period", last_per, PRE * NMD);
    chk("R1 mid high", last_high, PRE * NMD / 2);
    // R2: change mid-period, old period completes
    repeat (5) @(negedge clk);
    ratio_sel = 2'b00;
    wait_rise();
    chk("R2 old period kept", last_per, PRE * NMD);
    chk("R2 old high kept", last_high, PRE * NMD / 2);
    wait_rise();
    chk("R1 low period", last_per, PRE * NLO);
    chk("R1 low high", last_high, PRE * NLO / 2);
    repeat (7) @(negedge clk);
    ratio_sel = 2'b11;
    wait_rise();
    chk("R2 low period kept", last_per, PRE * NLO);
    wait_rise();
    chk("R1 high(11) period", last_per, PRE * NHI);
    chk("R1 high(11) high", last_high, PRE * NHI / 2);
    ratio_sel = 2'b10;
    wait_rise(); wait_rise();
    chk("R1 high(10) period", last_per, PRE * NHI);

    // R6: vector table, window 0 so lock cannot assert (R8)
    for (int i = 0; i < 6; i++) begin
      u0 = up_tot; d0 = dn_tot;
      compare(VECS[i][24], int'(VECS[i][23:16]));
      chk($sformatf("R6 vec%0d up width", i), up_tot - u0, int'(VECS[i][15:8]));
      chk($sformatf("R6 vec%0d dn width", i), dn_tot - d0, int'(VECS[i][7:0]));
    end
    chk("R8 zero window never locks", lock, 0);

    // R5 / R3: rising edges ignored in single-edge mode
    u0 = up_tot; d0 = dn_tot;
    @(negedge clk); ref_in = 1'b0; fb_in = 1'b0;
    repeat (3) @(negedge clk); ref_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 ref rise ignored", up_tot - u0, 0);
    fb_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 fb rise ignored", dn_tot - d0, 0);

    // R4: dual-edge mode, rising fb edge is valid
    dual_edge = 1'b1;
    @(negedge clk); ref_in = 1'b0; fb_in = 1'b0;
    repeat (3) @(negedge clk); ref_in = 1'b1;
    repeat (2) @(negedge clk);
    d0 = dn_tot;
    fb_in = 1'b1;
    repeat (3) @(negedge clk);
    ref_in = 1'b0;
    chk("R4 rise sets dn", pump_dn, 1);
    repeat (4) @(negedge clk);
    chk("R4 dn width", dn_tot - d0, 3);
    ref_in = 1'b1;
    repeat (2) @(negedge clk);
    dual_edge = 1'b0;
    fb_in = 1'b1;
    repeat (2) @(negedge clk);

    // R8 / R9: lock judgement with window 4
    lock_win = 12'd4;
    for (int i = 0; i < 7; i++) compare(1'b0, 2);
    chk("R8 not yet locked after 7", lock, 0);
    u0 = up_tot; d0 = dn_tot;
    compare(1'b0, 0);  // coincident edges as the 8th narrow comparison
    chk("R6 coincident no pulse", (up_tot - u0) + (dn_tot - d0), 0);
    chk("R8 locked after 8", lock, 1);
    chk("R10 lock_n inverse", lock_n, 0);
    compare(1'b1, 3);
    chk("R9 width win-1 keeps lock", lock, 1);
    compare(1'b0, 4);
    chk("R9 width win drops lock", lock, 0);
    chk("R10 lock_n after drop", lock_n, 1);

    chk("R7 pump_en tracks pumps", en_bad, 0);
    chk("R10 lock_n always inverse", lockn_bad, 0);

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks = checks + 1;
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule